// File: doc/BRIEF.md
# UART FIFO Transfer Request Generator

This block drives the two active-low request pins that tell a host or a DMA engine when a UART's byte FIFOs need service: a receive request, asserted when received bytes are waiting, and a transmit request (the pin is high when the transmit side can take no more data). It watches the fill counts of both FIFOs, the selected receive trigger level, a receive timeout pulse and the FIFO clear strobes. It does not contain the FIFOs, the timeout counter or the register decode.

A single mode input, taken from bit 3 of the FIFO control register, picks between two behaviours. In single-transfer mode (bit 3 = 0) each pin is a plain function of its FIFO's fill level. In block mode (bit 3 = 1) the receive request is asserted once a whole burst is worth fetching and held until the FIFO has been drained, which gives hysteresis. The transmit pin then stays low while there is any free space. Both pins are registered, so each reflects the inputs sampled at the previous rising clock edge.

Top module: `uart_xfer_req_gen`

## Requirements
- R1: After synchronous reset the receive request pin is high (1) and the transmit pin is low (0): single-transfer mode, both FIFOs treated as empty.
- R2: In single-transfer mode (mode input 0) the receive pin is 1 one cycle after the receive count is 0, and 0 one cycle after it is nonzero.
- R3: In single-transfer mode the transmit pin is 0 one cycle after the transmit count is 0, and 1 one cycle after it is nonzero.
- R4: In block mode (mode input 1) the transmit pin is 1 one cycle after the transmit count equals the FIFO depth (16), and 0 otherwise.
- R5: In block mode the receive pin goes to 0 one cycle after the receive count is nonzero and at or above the trigger level, or one cycle after a timeout pulse while the count is nonzero.
- R6: In block mode, once low, the receive pin stays 0 while the count stays nonzero, even below the trigger level. It returns to 1 one cycle after the count is 0.
- R7: The 2-bit trigger select maps 0 to 1 byte, 1 to 4 bytes, 2 to 8 bytes and 3 to 14 bytes.
- R8: A receive FIFO clear strobe makes the receive pin 1 on the next cycle in both modes. In block mode the pin then stays high until a new R5 event occurs.
- R9: A transmit FIFO clear strobe makes the transmit pin 0 on the next cycle in both modes.
- R10: On the first cycle in block mode after single-transfer mode, the receive pin is set only from the current inputs: 0 if an R5 event is present, 1 otherwise. Whatever level single-transfer mode left on the pin is disregarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| block_mode_i | input | 1 | FIFO control bit 3: 0 single-transfer, 1 block mode |
| rx_level_i | input | 5 | Receive FIFO fill count (0 to 16) |
| rx_trig_sel_i | input | 2 | Receive trigger select |
| rx_timeout_i | input | 1 | Receive timeout pulse |
| rx_flush_i | input | 1 | Receive FIFO clear strobe |
| tx_level_i | input | 5 | Transmit FIFO fill count (0 to 16) |
| tx_flush_i | input | 1 | Transmit FIFO clear strobe |
| rx_req_n_o | output | 1 | Receive request, active low |
| tx_req_n_o | output | 1 | Transmit-side pin, active low |

## Verification
The checker tests the level rules on every cycle: the single-transfer mapping of both counts, the full-FIFO rule for transmit in block mode, the forced values after either clear strobe, and the high pin after an empty receive FIFO. It also checks that a block-mode request is asserted at the trigger level and that, once asserted, it holds while data remains. Sequences that depend on history are left to the bench scenarios: walking each trigger selection up to its level and back down to empty, a timeout below the trigger level, a clear followed by stale data, and the two directions of a mode change, where block mode must re-derive the pin instead of inheriting it.

// File: rtl/uart_xfer_req_pkg.sv
package uart_xfer_req_pkg;

    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BLOCK  = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic rx_req_n;
        logic tx_req_n;
    } req_pins_t;

    // Trigger byte count for a 2-bit selection, scaled to the FIFO depth
    function automatic int unsigned rx_trig_bytes(logic [1:0] sel, int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_rxreq_ctl.sv
module uart_rxreq_ctl
    import uart_xfer_req_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  xfer_mode_e       mode,
    input  xfer_mode_e       mode_q,
    input  logic [CNT_W-1:0] level,
    input  logic [1:0]       trig_sel,
    input  logic             timeout,
    input  logic             flush,
    output logic             req_n
);

    logic [CNT_W-1:0] trig_lvl;
    logic             empty;
    logic             burst_due;
    logic             req_n_d;

    assign trig_lvl  = CNT_W'(rx_trig_bytes(trig_sel, DEPTH));
    assign empty     = (level == '0);
    assign burst_due = !empty && ((level >= trig_lvl) || timeout);

    always_comb begin
        if (flush) begin
            req_n_d = 1'b1;
        end else if (mode == XFER_SINGLE) begin
            req_n_d = empty;
        end else if (empty) begin
            req_n_d = 1'b1;
        end else if (burst_due) begin
            req_n_d = 1'b0;
        end else if (mode_q == XFER_SINGLE) begin
            req_n_d = 1'b1;      // entering block mode: rebuild from status
        end else begin
            req_n_d = req_n;     // hysteresis hold
        end
    end

    always_ff @(posedge clk) begin
        if (rst) req_n <= 1'b1;
        else     req_n <= req_n_d;
    end

endmodule

// File: rtl/uart_txreq_ctl.sv
module uart_txreq_ctl
    import uart_xfer_req_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  xfer_mode_e       mode,
    input  logic [CNT_W-1:0] level,
    input  logic             flush,
    output logic             req_n
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    logic req_n_d;

    always_comb begin
        if (flush)                     req_n_d = 1'b0;
        else if (mode == XFER_SINGLE)  req_n_d = (level != '0);
        else                           req_n_d = (level == FULL_LVL);
    end

    always_ff @(posedge clk) begin
        if (rst) req_n <= 1'b0;
        else     req_n <= req_n_d;
    end

endmodule

// File: rtl/uart_xfer_req_gen.sv
module uart_xfer_req_gen
    import uart_xfer_req_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             block_mode_i,
    input  logic [CNT_W-1:0] rx_level_i,
    input  logic [1:0]       rx_trig_sel_i,
    input  logic             rx_timeout_i,
    input  logic             rx_flush_i,
    input  logic [CNT_W-1:0] tx_level_i,
    input  logic             tx_flush_i,
    output logic             rx_req_n_o,
    output logic             tx_req_n_o
);

    xfer_mode_e mode;
    xfer_mode_e mode_q;
    req_pins_t  pins;

    assign mode = block_mode_i ? XFER_BLOCK : XFER_SINGLE;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= XFER_SINGLE;
        else     mode_q <= mode;
    end

    uart_rxreq_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .mode_q   (mode_q),
        .level    (rx_level_i),
        .trig_sel (rx_trig_sel_i),
        .timeout  (rx_timeout_i),
        .flush    (rx_flush_i),
        .req_n    (pins.rx_req_n)
    );

    uart_txreq_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .level (tx_level_i),
        .flush (tx_flush_i),
        .req_n (pins.tx_req_n)
    );

    assign rx_req_n_o = pins.rx_req_n;
    assign tx_req_n_o = pins.tx_req_n;

endmodule

// File: rtl/uart_xfer_req_chk.sv
module uart_xfer_req_chk
    import uart_xfer_req_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             block_mode_i,
    input logic [CNT_W-1:0] rx_level_i,
    input logic [1:0]       rx_trig_sel_i,
    input logic             rx_timeout_i,
    input logic             rx_flush_i,
    input logic [CNT_W-1:0] tx_level_i,
    input logic             tx_flush_i,
    input logic             rx_req_n_o,
    input logic             tx_req_n_o
);

    logic blk_seen;
    logic [CNT_W-1:0] thr;

    assign thr = CNT_W'(rx_trig_bytes(rx_trig_sel_i, DEPTH));

    always_ff @(posedge clk) begin
        if (rst) blk_seen <= 1'b0;
        else     blk_seen <= block_mode_i;
    end

    a_r2_single_rx: assert property (@(posedge clk) disable iff (rst)
        (!block_mode_i && !rx_flush_i) |=> (rx_req_n_o == $past(rx_level_i == '0)));

    a_r3_single_tx: assert property (@(posedge clk) disable iff (rst)
        (!block_mode_i && !tx_flush_i) |=> (tx_req_n_o == $past(tx_level_i != '0)));

    a_r4_block_tx_full: assert property (@(posedge clk) disable iff (rst)
        (block_mode_i && !tx_flush_i) |=> (tx_req_n_o == $past(tx_level_i == CNT_W'(DEPTH))));

    a_r5_block_trig: assert property (@(posedge clk) disable iff (rst)
        (block_mode_i && !rx_flush_i && rx_level_i != '0 && rx_level_i >= thr) |=> !rx_req_n_o);

    a_r6_block_hold: assert property (@(posedge clk) disable iff (rst)
        (block_mode_i && blk_seen && !rx_flush_i && rx_level_i != '0 && !rx_req_n_o) |=> !rx_req_n_o);

    a_r6_empty_high: assert property (@(posedge clk) disable iff (rst)
        (rx_level_i == '0) |=> rx_req_n_o);

    a_r8_rx_flush: assert property (@(posedge clk) disable iff (rst)
        rx_flush_i |=> rx_req_n_o);

    a_r9_tx_flush: assert property (@(posedge clk) disable iff (rst)
        tx_flush_i |=> !tx_req_n_o);

endmodule

bind uart_xfer_req_gen uart_xfer_req_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .block_mode_i  (block_mode_i),
    .rx_level_i    (rx_level_i),
    .rx_trig_sel_i (rx_trig_sel_i),
    .rx_timeout_i  (rx_timeout_i),
    .rx_flush_i    (rx_flush_i),
    .tx_level_i    (tx_level_i),
    .tx_flush_i    (tx_flush_i),
    .rx_req_n_o    (rx_req_n_o),
    .tx_req_n_o    (tx_req_n_o)
);

// File: tb/uart_xfer_req_gen_bench.sv
module uart_xfer_req_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       block_mode_i = 1'b0;
    logic [4:0] rx_level_i = '0;
    logic [1:0] rx_trig_sel_i = '0;
    logic       rx_timeout_i = 1'b0;
    logic       rx_flush_i = 1'b0;
    logic [4:0] tx_level_i = '0;
    logic       tx_flush_i = 1'b0;
    logic       rx_req_n_o;
    logic       tx_req_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    uart_xfer_req_gen u_uart_xfer_req_gen (
        .clk(clk), .rst(rst), .block_mode_i(block_mode_i),
        .rx_level_i(rx_level_i), .rx_trig_sel_i(rx_trig_sel_i),
        .rx_timeout_i(rx_timeout_i), .rx_flush_i(rx_flush_i),
        .tx_level_i(tx_level_i), .tx_flush_i(tx_flush_i),
        .rx_req_n_o(rx_req_n_o), .tx_req_n_o(tx_req_n_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // inputs are applied at a falling edge; one rising edge later, check at the next falling edge
    task automatic step();
        @(negedge clk);
        rx_timeout_i = 1'b0;
        rx_flush_i   = 1'b0;
        tx_flush_i   = 1'b0;
    endtask

    function automatic logic [4:0] trig_of(input int sel);
        case (sel)
            0: return 5'd1;
            1: return 5'd4;
            2: return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    task automatic t_reset();
        chk("R1 rx after reset", rx_req_n_o, 1'b1);
        chk("R1 tx after reset", tx_req_n_o, 1'b0);
    endtask

    task automatic t_single();
        block_mode_i = 1'b0;
        rx_level_i = 5'd1; step(); chk("R2 rx one byte", rx_req_n_o, 1'b0);
        rx_level_i = 5'd9; step(); chk("R2 rx nine bytes", rx_req_n_o, 1'b0);
        rx_level_i = 5'd0; step(); chk("R2 rx empty", rx_req_n_o, 1'b1);
        tx_level_i = 5'd3;  step(); chk("R3 tx partial", tx_req_n_o, 1'b1);
        tx_level_i = 5'd16; step(); chk("R3 tx full", tx_req_n_o, 1'b1);
        tx_level_i = 5'd0;  step(); chk("R3 tx empty", tx_req_n_o, 1'b0);
    endtask

    task automatic t_block_tx();
        block_mode_i = 1'b1;
        tx_level_i = 5'd16; step(); chk("R4 tx full", tx_req_n_o, 1'b1);
        tx_level_i = 5'd15; step(); chk("R4 tx one free", tx_req_n_o, 1'b0);
        tx_level_i = 5'd0;  step(); chk("R4 tx empty", tx_req_n_o, 1'b0);
    endtask

    task automatic t_block_trig();
        block_mode_i = 1'b1;
        for (int s = 0; s < 4; s++) begin
            logic [4:0] lv;
            lv = trig_of(s);
            rx_trig_sel_i = 2'(s);
            rx_level_i = 5'd0; step();
            chk("R7 start empty", rx_req_n_o, 1'b1);
            if (lv > 5'd1) begin
                rx_level_i = lv - 5'd1; step();
                chk("R7 below trigger", rx_req_n_o, 1'b1);
            end
            rx_level_i = lv; step();
            chk("R5 R7 at trigger", rx_req_n_o, 1'b0);
            rx_level_i = 5'd1; step();
            chk("R6 hold while draining", rx_req_n_o, 1'b0);
            rx_level_i = 5'd0; step();
            chk("R6 release on empty", rx_req_n_o, 1'b1);
        end
    endtask

    task automatic t_timeout();
        block_mode_i = 1'b1; rx_trig_sel_i = 2'd3;
        rx_level_i = 5'd3; step(); chk("R5 below trigger idle", rx_req_n_o, 1'b1);
        rx_timeout_i = 1'b1; step(); chk("R5 timeout asserts", rx_req_n_o, 1'b0);
        step(); chk("R6 hold after timeout", rx_req_n_o, 1'b0);
        rx_level_i = 5'd0; step(); chk("R6 empty after timeout", rx_req_n_o, 1'b1);
        rx_timeout_i = 1'b1; step(); chk("R5 timeout on empty ignored", rx_req_n_o, 1'b1);
    endtask

    task automatic t_flush();
        block_mode_i = 1'b1; rx_trig_sel_i = 2'd1;
        rx_level_i = 5'd6; step(); chk("R5 block low", rx_req_n_o, 1'b0);
        rx_flush_i = 1'b1; rx_level_i = 5'd2; step(); chk("R8 flush block", rx_req_n_o, 1'b1);
        step(); chk("R8 stays high below trigger", rx_req_n_o, 1'b1);
        block_mode_i = 1'b0; rx_level_i = 5'd5;
        rx_flush_i = 1'b1; step(); chk("R8 flush single", rx_req_n_o, 1'b1);
        step(); chk("R2 after flush", rx_req_n_o, 1'b0);
        tx_level_i = 5'd5; tx_flush_i = 1'b1; step(); chk("R9 tx flush single", tx_req_n_o, 1'b0);
        block_mode_i = 1'b1; tx_level_i = 5'd16; tx_flush_i = 1'b1; step();
        chk("R9 tx flush block", tx_req_n_o, 1'b0);
        step(); chk("R4 full after flush", tx_req_n_o, 1'b1);
        tx_level_i = 5'd0; rx_level_i = 5'd0; step();
    endtask

    task automatic t_mode_change();
        block_mode_i = 1'b0; rx_trig_sel_i = 2'd2;
        rx_level_i = 5'd2; step(); chk("R2 single with data", rx_req_n_o, 1'b0);
        block_mode_i = 1'b1; step(); chk("R10 reinit below trigger", rx_req_n_o, 1'b1);
        rx_level_i = 5'd10; step(); chk("R5 block trigger", rx_req_n_o, 1'b0);
        rx_level_i = 5'd2; step(); chk("R6 hold", rx_req_n_o, 1'b0);
        block_mode_i = 1'b0; step(); chk("R2 back to single", rx_req_n_o, 1'b0);
        block_mode_i = 1'b1; step(); chk("R10 no inherited low", rx_req_n_o, 1'b1);
        block_mode_i = 1'b0; step();
        block_mode_i = 1'b1; rx_level_i = 5'd9; step(); chk("R10 reinit at trigger", rx_req_n_o, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_block_tx();
        t_block_trig();
        t_timeout();
        t_flush();
        t_mode_change();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule